// File: doc/BRIEF.md
# Lockable Video Control Register Write Filter

This block holds a bank of 64 eight-bit video control registers and decides which register a host write updates. A host write presents a strobe, a six-bit register index and a data byte. Two inputs steer the decision: a lock flag and the 80-column mode flag. While the lock flag is clear, the full index reaches the bank. While it is set, the block follows the older, narrower register space. With 80-column mode off, the index wraps into registers 0 to 7. With 80-column mode on, any write above register 7 is dropped.

A one-cycle restore command loads the power-on values into the lower registers and leaves the top registers alone. The bank contents are the block's output. The block also gives a view of the 80-column name-table base, which has 1K alignment when unlocked and 4K alignment when locked, and the enable bit for the simulated scan-line dimming. The lock flag is an input and nothing inside the block changes it.

Top module: `vctl_wrfilt`

## Requirements
- R1: While `locked_i` is low, a write with `wr_en_i` high stores `wr_data_i` into the register given by the full six-bit `wr_idx_i` (0 to 63) on the next clock edge.
- R2: While `locked_i` is high and `col80_i` is low, a write stores into the register given by `wr_idx_i[2:0]`. For example, index 13 updates register 5 and index 42 updates register 2.
- R3: While `locked_i` and `col80_i` are both high, a write to an index above 7 changes no register. A write to an index from 0 to 7 stores normally.
- R4: A cycle with `restore_i` high loads the power-on values into registers 0 to 57 on the next edge: register 1 gets 0x40, register 7 gets 0xF0 and every other register gets 0x00. Registers 58 to 63 keep their contents.
- R5: When `restore_i` and `wr_en_i` are high in the same cycle, the restore takes effect and the write is discarded, even when the write targets a register from 58 to 63.
- R6: `nt_base_o` equals bits [3:0] of register 2 while `locked_i` is low. While `locked_i` is high, it equals bits [3:2] of register 2 followed by 2'b00.
- R7: `scanline_en_o` equals bit 2 of register 50.
- R8: After `rst_n` is released, every register holds its power-on value as listed in R4, and registers 58 to 63 hold 0x00.
- R9: A cycle with neither `wr_en_i` nor `restore_i` high leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low; loads power-on values |
| wr_en_i | input | 1 | Host write strobe, one cycle per write |
| wr_idx_i | input | 6 | Register index of the host write |
| wr_data_i | input | 8 | Write data |
| locked_i | input | 1 | Lock state; high restricts the register space |
| col80_i | input | 1 | 80-column mode flag |
| restore_i | input | 1 | Restore-to-defaults command, one cycle |
| regs_o | output | 512 | Bank contents; register n occupies bits [8n+7:8n] |
| nt_base_o | output | 4 | 80-column name-table base after the lock override |
| scanline_en_o | output | 1 | Simulated scan-line dimming enable |

## Verification
The hardest case to reach is a restore arriving in the same cycle as a write that targets one of the preserved top registers. A mistaken priority there leaves no trace unless that register already holds a known non-default value. So the stimulus first writes register 60 while unlocked, then fires the restore together with a write to register 60 and checks that the old byte survives. The lock-dependent paths need a similar setup: aliased and dropped writes only show up because every register is compared after each operation.

// File: rtl/vctl_pkg.sv
package vctl_pkg;
    localparam int NREG      = 64;
    localparam int DW        = 8;
    localparam int KEEP_FROM = 58;
    localparam int NT_REG    = 2;
    localparam int SCAN_REG  = 50;
    localparam int SCAN_BIT  = 2;

    function automatic logic [DW-1:0] pon_value(input int idx);
        case (idx)
            1:       return 8'h40;
            7:       return 8'hF0;
            default: return '0;
        endcase
    endfunction
endpackage

// File: rtl/vctl_idx_gate.sv
module vctl_idx_gate #(
    parameter int NREG      = vctl_pkg::NREG,
    parameter int LOCK_SPAN = 8,
    localparam int IW       = $clog2(NREG),
    localparam int LW       = $clog2(LOCK_SPAN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en_i,
    input  logic [IW-1:0] wr_idx_i,
    input  logic          locked_i,
    input  logic          col80_i,
    output logic          hit_o,
    output logic [IW-1:0] tgt_o
);
    logic [IW-1:0] masked;
    logic          above_span;

    generate
        if (NREG > LOCK_SPAN) begin : g_wide
            assign masked     = {{(IW-LW){1'b0}}, wr_idx_i[LW-1:0]};
            assign above_span = (wr_idx_i >= IW'(LOCK_SPAN));
        end else begin : g_narrow
            assign masked     = wr_idx_i;
            assign above_span = 1'b0;
        end
    endgenerate

    always_comb begin
        hit_o = wr_en_i;
        tgt_o = wr_idx_i;
        if (locked_i) begin
            if (col80_i) begin
                if (above_span) hit_o = 1'b0;
            end else begin
                tgt_o = masked;
            end
        end
    end

    assert_locked_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && locked_i && !col80_i) |-> (hit_o && tgt_o < IW'(LOCK_SPAN)));
    assert_col80_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_i && col80_i && wr_idx_i >= IW'(LOCK_SPAN)) |-> !hit_o);
endmodule

// File: rtl/vctl_bank.sv
module vctl_bank #(
    parameter int NREG      = vctl_pkg::NREG,
    parameter int DW        = vctl_pkg::DW,
    parameter int KEEP_FROM = vctl_pkg::KEEP_FROM,
    localparam int IW       = $clog2(NREG)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    hit_i,
    input  logic [IW-1:0]           tgt_i,
    input  logic [DW-1:0]           data_i,
    input  logic                    restore_i,
    output logic [NREG-1:0][DW-1:0] regs_o
);
    typedef struct packed {
        logic [NREG-1:0][DW-1:0] regs;
    } bank_t;

    bank_t st_d, st_q;

    function automatic bank_t pon_bank();
        bank_t b;
        for (int i = 0; i < NREG; i++) b.regs[i] = vctl_pkg::pon_value(i);
        return b;
    endfunction

    always_comb begin
        st_d = st_q;
        if (restore_i) begin
            for (int i = 0; i < KEEP_FROM; i++) st_d.regs[i] = vctl_pkg::pon_value(i);
        end else if (hit_i) begin
            st_d.regs[tgt_i] = data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= pon_bank();
        else        st_q <= st_d;
    end

    assign regs_o = st_q.regs;

    assert_write_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_i && !restore_i) |=> (st_q.regs[$past(tgt_i)] == $past(data_i)));
    assert_restore_pon_R4: assert property (@(posedge clk) disable iff (!rst_n)
        restore_i |=> (st_q.regs[1] == 8'h40 && st_q.regs[7] == 8'hF0));
    assert_restore_keeps_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
        restore_i |=> (st_q.regs[NREG-1] == $past(st_q.regs[NREG-1])));
    assert_restore_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_i && hit_i) |=> (st_q.regs[KEEP_FROM] == $past(st_q.regs[KEEP_FROM])));
    assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_i && !restore_i) |=> $stable(st_q.regs));
endmodule

// File: rtl/vctl_view.sv
module vctl_view #(
    parameter int NREG     = vctl_pkg::NREG,
    parameter int DW       = vctl_pkg::DW,
    parameter int NT_REG   = vctl_pkg::NT_REG,
    parameter int SCAN_REG = vctl_pkg::SCAN_REG,
    parameter int SCAN_BIT = vctl_pkg::SCAN_BIT
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NREG-1:0][DW-1:0] regs_i,
    input  logic                    locked_i,
    output logic [3:0]              nt_base_o,
    output logic                    scanline_en_o
);
    logic [3:0] nt_raw;

    assign nt_raw        = regs_i[NT_REG][3:0];
    assign nt_base_o     = locked_i ? {nt_raw[3:2], 2'b00} : nt_raw;
    assign scanline_en_o = regs_i[SCAN_REG][SCAN_BIT];

    assert_nt_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
        locked_i |-> (nt_base_o[1:0] == 2'b00 && nt_base_o[3:2] == regs_i[NT_REG][3:2]));
endmodule

// File: rtl/vctl_wrfilt.sv
module vctl_wrfilt (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en_i,
    input  logic [5:0]   wr_idx_i,
    input  logic [7:0]   wr_data_i,
    input  logic         locked_i,
    input  logic         col80_i,
    input  logic         restore_i,
    output logic [511:0] regs_o,
    output logic [3:0]   nt_base_o,
    output logic         scanline_en_o
);
    localparam int NREG = vctl_pkg::NREG;
    localparam int DW   = vctl_pkg::DW;
    localparam int IW   = $clog2(NREG);

    logic                    hit;
    logic [IW-1:0]           tgt;
    logic [NREG-1:0][DW-1:0] bank;

    vctl_idx_gate #(.NREG(NREG), .LOCK_SPAN(8)) u_gate (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i),
        .locked_i(locked_i), .col80_i(col80_i), .hit_o(hit), .tgt_o(tgt)
    );

    vctl_bank #(.NREG(NREG), .DW(DW), .KEEP_FROM(vctl_pkg::KEEP_FROM)) u_bank (
        .clk(clk), .rst_n(rst_n), .hit_i(hit), .tgt_i(tgt), .data_i(wr_data_i),
        .restore_i(restore_i), .regs_o(bank)
    );

    vctl_view #(.NREG(NREG), .DW(DW)) u_view (
        .clk(clk), .rst_n(rst_n), .regs_i(bank), .locked_i(locked_i),
        .nt_base_o(nt_base_o), .scanline_en_o(scanline_en_o)
    );

    assign regs_o = bank;
endmodule

// File: tb/sim_vctl_wrfilt.sv
module sim_vctl_wrfilt;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en_i = 1'b0;
    logic [5:0]   wr_idx_i = '0;
    logic [7:0]   wr_data_i = '0;
    logic         locked_i = 1'b0;
    logic         col80_i = 1'b0;
    logic         restore_i = 1'b0;
    logic [511:0] regs_o;
    logic [3:0]   nt_base_o;
    logic         scanline_en_o;

    always #2.5 clk = ~clk;

    vctl_wrfilt u0 (.*);

    typedef struct {
        int         due;
        int         slot;
        logic [7:0] exp;
        string      req;
    } item_t;

    item_t      sb[$];
    logic [7:0] model [64];
    int         cyc = 0;
    int         compared = 0;
    int         mismatched = 0;
    bit         done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] pon(input int i);
        return (i == 1) ? 8'h40 : (i == 7) ? 8'hF0 : 8'h00;
    endfunction

    // monitor: slot 0..63 register, 64 name-table base, 65 scan-line enable
    always @(posedge clk) begin
        #1;
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            item_t it;
            logic [7:0] act;
            it = sb.pop_front();
            if (it.slot < 64)       act = regs_o[it.slot*8 +: 8];
            else if (it.slot == 64) act = {4'h0, nt_base_o};
            else                    act = {7'h0, scanline_en_o};
            compared++;
            if (act !== it.exp) begin
                mismatched++;
                $display("FAIL %s slot %0d actual %h expected %h", it.req, it.slot, act, it.exp);
            end
        end
    end

    task automatic op(input bit we, input int idx, input logic [7:0] d,
                      input bit lk, input bit c80, input bit rs, input string req);
        @(negedge clk);
        wr_en_i = we; wr_idx_i = 6'(idx); wr_data_i = d;
        locked_i = lk; col80_i = c80; restore_i = rs;
        if (rs) begin
            for (int i = 0; i < 58; i++) model[i] = pon(i);
        end else if (we) begin
            if (!lk)                  model[idx] = d;
            else if (!c80)            model[idx % 8] = d;
            else if (idx < 8)         model[idx] = d;
        end
        for (int i = 0; i < 64; i++) sb.push_back('{cyc + 1, i, model[i], req});
        sb.push_back('{cyc + 1, 64, lk ? {4'h0, model[2][3:2], 2'b00} : {4'h0, model[2][3:0]}, "R6"});
        sb.push_back('{cyc + 1, 65, {7'h0, model[50][2]}, "R7"});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) model[i] = pon(i);
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        op(0, 0, 8'h00, 0, 0, 0, "R8");
        // unlocked full index
        op(1, 13, 8'hA5, 0, 0, 0, "R1");
        op(1, 63, 8'h3C, 0, 0, 0, "R1");
        op(1, 50, 8'h04, 0, 0, 0, "R7");
        op(1, 2,  8'h0F, 0, 0, 0, "R6");
        // locked, index wraps
        op(1, 13, 8'h5A, 1, 0, 0, "R2");
        op(1, 42, 8'h11, 1, 0, 0, "R2");
        op(1, 2,  8'h0E, 1, 0, 0, "R6");
        op(0, 0,  8'h00, 0, 0, 0, "R6");
        // locked with 80 columns: drop above 7
        op(1, 20, 8'h77, 1, 1, 0, "R3");
        op(1, 6,  8'h66, 1, 1, 0, "R3");
        op(1, 63, 8'hEE, 1, 1, 0, "R3");
        op(0, 9,  8'hCC, 1, 1, 0, "R9");
        op(0, 9,  8'hCC, 0, 0, 0, "R9");
        // restore
        op(1, 60, 8'h99, 0, 0, 0, "R1");
        op(0, 0,  8'h00, 1, 0, 1, "R4");
        op(1, 20, 8'h21, 0, 0, 0, "R1");
        op(1, 60, 8'h12, 0, 0, 1, "R5");
        op(1, 3,  8'h34, 1, 0, 1, "R5");
        // scan-line bit
        op(1, 50, 8'h04, 0, 0, 0, "R7");
        op(1, 50, 8'hFB, 0, 0, 0, "R7");
        op(0, 0,  8'h00, 0, 0, 0, "R9");
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule